// File: doc/BRIEF.md
# Tag-Check Fault Dispatcher

This block decides the consequence of a failed memory-tag comparison. When the tag comparator reports a mismatch, the dispatcher reads a 2-bit fault-handling mode out of the system control word, selects the reporting exception level and then does one of three things. It may raise a synchronous data abort that carries the faulting virtual address and a syndrome. It may instead record the failure as a sticky bit in an asynchronous fault status register kept per exception level. Otherwise it drops the failure.

The mode field depends on the regime. A regime that serves EL0 takes its mode from one field of the control word, and it always reports at level 0. A privileged regime takes its mode from a second field and reports at its own exception level. An asynchronous record sets one of two status bits. Address bit 55 selects that bit when the regime splits its address space into two ranges. Otherwise bit 0 is used. Software reads the four status registers through a small register port and clears bits by writing a mask. Accesses that skip tag checking never raise the failure strobe. Taking the exception is left to the core.

Top module: `tag_fault_dispatch`

## Requirements
- R1: For an EL0 regime (`el0_regime_i`=1) the mode is `sctlr_i[39:38]` and the reporting level is 0. Otherwise the mode is `sctlr_i[41:40]` and the reporting level is `el_i`.
- R2: In mode 1, the cycle after `fail_i` is sampled high shows `abort_o` high for exactly that one cycle, with `abort_addr_o` equal to the sampled `addr_i`. Back-to-back failures give back-to-back pulses.
- R3: The abort syndrome `abort_syn_o` holds fault status code 0x11 in bits [5:0] and the sampled `write_i` in bit 6. All other bits are zero.
- R4: `abort_same_lvl_o` is 1 with an abort exactly when the reporting level is nonzero.
- R5: In mode 2, no abort is raised. In the cycle after the failure, status register [reporting level] has bit `select` set, and the other registers and bits are unchanged.
- R6: `select` equals `addr_i[55]` when `two_range_i`=1, and 0 otherwise.
- R7: In mode 0 and mode 3 a failure raises no abort and changes no status bit.
- R8: Status bits are sticky. A cycle with `reg_wr_i`=1 clears the bits of register `reg_sel_i` that are set in `reg_wdata_i`. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: After reset `abort_o` is low and all status registers read 0. `reg_rdata_o` shows register `reg_sel_i` combinationally.
- R10: `abort_addr_o`, `abort_syn_o` and `abort_same_lvl_o` hold their values until the next abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fail_i | input | 1 | Tag check failure strobe |
| addr_i | input | 64 | Faulting virtual address |
| write_i | input | 1 | Failing access was a write |
| el_i | input | 2 | Exception level of the translation regime |
| el0_regime_i | input | 1 | Regime is an EL0 regime |
| two_range_i | input | 1 | Regime has two virtual address ranges |
| sctlr_i | input | 64 | System control word |
| reg_sel_i | input | 2 | Status register index for read and clear |
| reg_wr_i | input | 1 | Clear strobe |
| reg_wdata_i | input | 2 | Clear mask |
| reg_rdata_o | output | 2 | Selected status register |
| abort_o | output | 1 | Synchronous abort pulse |
| abort_addr_o | output | 64 | Registered fault address |
| abort_syn_o | output | 25 | Registered syndrome |
| abort_same_lvl_o | output | 1 | Abort reported at a nonzero level |

## Verification
If the mode decode or the level selection is wrong, the error shows in the cycle after the failure. The design then raises an abort the scoreboard did not expect, or misses an expected one, or sets a status bit in the wrong register. A wrong status register is invisible at the abort outputs. It becomes visible only on a read, so the bench reads all four registers after each group of failures. A missing set-over-clear priority, or a sticky bit that leaks, shows up only on the read after the colliding cycle.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  typedef enum logic [1:0] {
    TCF_NONE  = 2'd0,
    TCF_SYNC  = 2'd1,
    TCF_ASYNC = 2'd2,
    TCF_RSVD  = 2'd3
  } tcf_mode_e;

  localparam int unsigned SYN_W   = 25;
  localparam int unsigned FSC_W   = 6;
  localparam logic [5:0]  FSC_TAG = 6'h11;
  localparam int unsigned WNR_BIT = 6;
endpackage

// File: rtl/tfd_mode_sel.sv
module tfd_mode_sel #(
  parameter int unsigned CTRL_W  = 64,
  parameter int unsigned USR_LSB = 38,
  parameter int unsigned PRV_LSB = 40,
  parameter int unsigned LVL_W   = 2
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              el0_regime_i,
  input  logic [LVL_W-1:0]  el_i,
  output tfd_pkg::tcf_mode_e mode_o,
  output logic [LVL_W-1:0]  rpt_lvl_o
);
  import tfd_pkg::*;

  logic [1:0] usr_f, prv_f;
  assign usr_f = ctrl_i[USR_LSB +: 2];
  assign prv_f = ctrl_i[PRV_LSB +: 2];

  always_comb begin
    if (el0_regime_i) begin
      mode_o    = tcf_mode_e'(usr_f);
      rpt_lvl_o = '0;
    end else begin
      mode_o    = tcf_mode_e'(prv_f);
      rpt_lvl_o = el_i;
    end
  end
endmodule

// File: rtl/tfd_sync_report.sv
module tfd_sync_report #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SYN_W  = tfd_pkg::SYN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              same_lvl_i,
  output logic              abort_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic              same_lvl_o
);
  import tfd_pkg::*;

  logic [SYN_W-1:0] syn_d;

  always_comb begin
    syn_d                = '0;
    syn_d[FSC_W-1:0]     = FSC_TAG;
    syn_d[WNR_BIT]       = write_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_o    <= 1'b0;
      addr_o     <= '0;
      syn_o      <= '0;
      same_lvl_o <= 1'b0;
    end else begin
      abort_o <= fire_i;
      if (fire_i) begin
        addr_o     <= addr_i;
        syn_o      <= syn_d;
        same_lvl_o <= same_lvl_i;
      end
    end
  end

  a_r2_pulse_follows_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> abort_o);
  a_r2_no_spurious_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !abort_o);
  a_r3_fsc_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> syn_o[FSC_W-1:0] == FSC_TAG);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(addr_o) && $stable(syn_o));
endmodule

// File: rtl/tfd_async_status.sv
module tfd_async_status #(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned RNG     = 2,
  localparam int unsigned LVL_W  = $clog2(NUM_LVL),
  localparam int unsigned SEL_W  = $clog2(RNG)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_i,
  input  logic [LVL_W-1:0]              set_lvl_i,
  input  logic [SEL_W-1:0]              set_sel_i,
  input  logic                          clr_i,
  input  logic [LVL_W-1:0]              clr_lvl_i,
  input  logic [RNG-1:0]                clr_mask_i,
  input  logic [LVL_W-1:0]              rd_lvl_i,
  output logic [RNG-1:0]                rd_o,
  output logic [NUM_LVL-1:0][RNG-1:0]   stat_o
);
  logic [NUM_LVL-1:0][RNG-1:0] stat_q;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar b = 0; b < RNG; b++) begin : g_bit
      logic set_hit, clr_hit;
      assign set_hit = set_i && (set_lvl_i == LVL_W'(l)) && (set_sel_i == SEL_W'(b));
      assign clr_hit = clr_i && (clr_lvl_i == LVL_W'(l)) && clr_mask_i[b];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stat_q[l][b] <= 1'b0;
        else if (set_hit) stat_q[l][b] <= 1'b1;
        else if (clr_hit) stat_q[l][b] <= 1'b0;
      end

      a_r5_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_hit |=> stat_q[l][b]);
      a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_q[l][b] && !clr_hit |=> stat_q[l][b]);
      a_r8_no_self_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_q[l][b] && !set_hit |=> !stat_q[l][b]);
    end
  end

  assign rd_o   = stat_q[rd_lvl_i];
  assign stat_o = stat_q;
endmodule

// File: rtl/tag_fault_dispatch.sv
module tag_fault_dispatch #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned CTRL_W   = 64,
  parameter int unsigned NUM_LVL  = 4,
  parameter int unsigned RNG      = 2,
  parameter int unsigned SEL_BIT  = 55,
  parameter int unsigned USR_LSB  = 38,
  parameter int unsigned PRV_LSB  = 40,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL),
  localparam int unsigned SEL_W   = $clog2(RNG),
  localparam int unsigned SYN_W   = tfd_pkg::SYN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [LVL_W-1:0]  el_i,
  input  logic              el0_regime_i,
  input  logic              two_range_i,
  input  logic [CTRL_W-1:0] sctlr_i,
  input  logic [LVL_W-1:0]  reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [RNG-1:0]    reg_wdata_i,
  output logic [RNG-1:0]    reg_rdata_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] abort_addr_o,
  output logic [SYN_W-1:0]  abort_syn_o,
  output logic              abort_same_lvl_o
);
  import tfd_pkg::*;

  tcf_mode_e                   mode;
  logic [LVL_W-1:0]            rpt_lvl;
  logic                        sync_fire, async_set;
  logic [SEL_W-1:0]            sel;
  logic [NUM_LVL-1:0][RNG-1:0] stat;

  tfd_mode_sel #(
    .CTRL_W (CTRL_W),
    .USR_LSB(USR_LSB),
    .PRV_LSB(PRV_LSB),
    .LVL_W  (LVL_W)
  ) u_mode (
    .ctrl_i      (sctlr_i),
    .el0_regime_i(el0_regime_i),
    .el_i        (el_i),
    .mode_o      (mode),
    .rpt_lvl_o   (rpt_lvl)
  );

  assign sync_fire = fail_i && (mode == TCF_SYNC);
  assign async_set = fail_i && (mode == TCF_ASYNC);
  assign sel       = two_range_i ? SEL_W'(addr_i[SEL_BIT]) : '0;

  tfd_sync_report #(
    .ADDR_W(ADDR_W),
    .SYN_W (SYN_W)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (sync_fire),
    .addr_i    (addr_i),
    .write_i   (write_i),
    .same_lvl_i(rpt_lvl != '0),
    .abort_o   (abort_o),
    .addr_o    (abort_addr_o),
    .syn_o     (abort_syn_o),
    .same_lvl_o(abort_same_lvl_o)
  );

  tfd_async_status #(
    .NUM_LVL(NUM_LVL),
    .RNG    (RNG)
  ) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (async_set),
    .set_lvl_i (rpt_lvl),
    .set_sel_i (sel),
    .clr_i     (reg_wr_i),
    .clr_lvl_i (reg_sel_i),
    .clr_mask_i(reg_wdata_i),
    .rd_lvl_i  (reg_sel_i),
    .rd_o      (reg_rdata_o),
    .stat_o    (stat)
  );

  a_r7_ignored_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i && (sctlr_i[USR_LSB +: 2] != 2'd1) && el0_regime_i && !reg_wr_i
      && (sctlr_i[USR_LSB +: 2] != 2'd2) |=> !abort_o && $stable(stat));
  a_r5_async_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_set |=> !abort_o);
  a_r4_el0_not_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i && el0_regime_i |=> !abort_same_lvl_o || !abort_o);
endmodule

// File: tb/tag_fault_dispatch_bench.sv
`timescale 1ns/1ps
module tag_fault_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail = 1'b0;
  logic [63:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  el = '0;
  logic        el0 = 1'b0;
  logic        two = 1'b0;
  logic [63:0] sctlr = '0;
  logic [1:0]  rsel = '0;
  logic        rwr = 1'b0;
  logic [1:0]  rwdata = '0;
  logic [1:0]  rdata;
  logic        abort;
  logic [63:0] abort_addr;
  logic [24:0] abort_syn;
  logic        abort_same;

  tag_fault_dispatch u_tag_fault_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .fail_i(fail), .addr_i(addr), .write_i(wr),
    .el_i(el), .el0_regime_i(el0), .two_range_i(two), .sctlr_i(sctlr),
    .reg_sel_i(rsel), .reg_wr_i(rwr), .reg_wdata_i(rwdata), .reg_rdata_o(rdata),
    .abort_o(abort), .abort_addr_o(abort_addr), .abort_syn_o(abort_syn),
    .abort_same_lvl_o(abort_same)
  );

  always #4 clk = ~clk;

  typedef struct { logic [63:0] a; logic [24:0] s; logic same; } exp_t;
  exp_t        q[$];
  logic [1:0]  model [4];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected aborts
  always @(negedge clk) if (rst_n && abort) begin
    if (q.size() == 0) chk(0, "R7 unexpected abort", 128'(abort_addr), 0);
    else begin
      exp_t e;
      e = q.pop_front();
      chk(abort_addr == e.a, "R2 addr", 128'(abort_addr), 128'(e.a));
      chk(abort_syn == e.s, "R3 syndrome", 128'(abort_syn), 128'(e.s));
      chk(abort_same == e.same, "R4 same level", 128'(abort_same), 128'(e.same));
    end
  end

  // driver: one cycle of stimulus, model updated from requirements
  task automatic drive(input bit f, input logic [63:0] a, input bit w, input logic [1:0] l,
                       input bit e0, input bit tr, input logic [1:0] usr, input logic [1:0] prv,
                       input bit c, input logic [1:0] cl, input logic [1:0] cm);
    logic [1:0] mode, lvl;
    @(negedge clk);
    fail = f; addr = a; wr = w; el = l; el0 = e0; two = tr;
    sctlr = '0; sctlr[39:38] = usr; sctlr[41:40] = prv;
    rwr = c; rsel = cl; rwdata = cm;
    mode = e0 ? usr : prv;           // R1
    lvl  = e0 ? 2'd0 : l;
    if (c) model[cl] = model[cl] & ~cm;
    if (f && mode == 2'd1) begin
      exp_t e;
      e.a = a; e.s = 25'h11 | (25'(w) << 6); e.same = (lvl != 0);
      q.push_back(e);
    end
    if (f && mode == 2'd2) model[lvl][tr ? a[55] : 1'b0] = 1'b1;  // R5 R6
    @(negedge clk);
    fail = 0; rwr = 0;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 4; i++) begin
      rsel = 2'(i);
      #1;
      chk(rdata == model[i], req, 128'(rdata), 128'(model[i]));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk(abort == 0, "R9 abort reset", 128'(abort), 0);
    read_all("R9 status reset");

    // R1 R2 R3 R4: EL0 regime uses low field, el_i ignored
    drive(1, 64'h0123_4567_89ab_cdef, 1, 2'd1, 1, 0, 2'd1, 2'd2, 0, 0, 0);
    // privileged regime at level 2, read
    drive(1, 64'hfedc_0000_1111_2220, 0, 2'd2, 0, 0, 2'd0, 2'd1, 0, 0, 0);
    // R2 back-to-back pulses
    @(negedge clk);
    fail = 1; addr = 64'h10; wr = 0; el = 2'd3; el0 = 0; two = 0; sctlr = 64'h1 << 40;
    q.push_back('{64'h10, 25'h11, 1'b1});
    @(negedge clk);
    addr = 64'h20; wr = 1;
    q.push_back('{64'h20, 25'h51, 1'b1});
    @(negedge clk);
    fail = 0;
    @(negedge clk);
    chk(abort == 0, "R2 single pulse", 128'(abort), 0);
    chk(abort_addr == 64'h20, "R10 addr hold", 128'(abort_addr), 64'h20);

    // R5 R6: async, EL0 regime, two ranges, bit55 = 1
    drive(1, 64'h0080_0000_0000_0000, 0, 2'd2, 1, 1, 2'd2, 2'd1, 0, 0, 0);
    // async, privileged level 3, one range, bit55 = 1 -> bit0
    drive(1, 64'h0080_0000_0000_0040, 1, 2'd3, 0, 0, 2'd1, 2'd2, 0, 0, 0);
    // async, level 1, two ranges, bit55 = 0
    drive(1, 64'h0000_0000_0000_0080, 1, 2'd1, 0, 1, 2'd0, 2'd2, 0, 0, 0);
    read_all("R5 R6 status");
    chk(abort_addr == 64'h20, "R10 addr hold after async", 128'(abort_addr), 64'h20);

    // R7: modes 0 and 3 ignored
    drive(1, 64'h0080_0000_0000_0000, 1, 2'd2, 0, 1, 2'd1, 2'd0, 0, 0, 0);
    drive(1, 64'h0080_0000_0000_0000, 1, 2'd2, 0, 1, 2'd2, 2'd3, 0, 0, 0);
    drive(1, 64'h0, 0, 2'd0, 1, 0, 2'd3, 2'd1, 0, 0, 0);
    read_all("R7 status unchanged");

    // R8: clear bit1 of level 0, then re-set sticky, then set+clear collision
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 2'b10);
    read_all("R8 clear");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 2'b10);
    read_all("R8 clear unset bit");
    @(negedge clk);
    fail = 1; addr = 64'h0; el = 2'd3; el0 = 0; two = 0; sctlr = 64'h2 << 40;
    rwr = 1; rsel = 2'd3; rwdata = 2'b01;
    model[3][0] = 1'b1;
    @(negedge clk);
    fail = 0; rwr = 0;
    read_all("R8 set wins");
    repeat (3) @(negedge clk);
    read_all("R8 sticky");
    chk(q.size() == 0, "R2 all aborts seen", 128'(q.size()), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule